// File: doc/BRIEF.md
# Procedure Call-Trace Recorder

This block sits next to a processor core and watches two of its signals without disturbing them: the instruction register and the link register. Whenever a valid instruction matches the pattern that a compiler emits at procedure entry, the current link-register value is pushed onto a small internal stack. Whenever a valid instruction matches the procedure-exit pattern, the newest entry is dropped. The stack therefore mirrors the live chain of return addresses, and the block also keeps the deepest level reached.

Software talks to the block through two I/O words: a data word and a control/status word. A trap handler typically sets the freeze bit so that recording stops, rewinds the readout cursor, and then reads the data word repeatedly. Each read yields one return address, newest first, so the call chain can be listed from the innermost call outward. The stack, its depth, the peak depth and the error flags are kept across the hardware reset, so a trace taken just before a trap survives a system restart. Only an explicit software clear empties them.

Top module: `call_trace_recorder`

## Requirements
- R1: When `ir_valid` is high and `(ir & ENTRY_MASK) == ENTRY_VAL` (defaults mask 0xFFFF0000, value 0xAFE00000), and recording is not frozen, `lnk` is stored as the new top entry and the depth rises by one at the next clock edge.
- R2: When `ir_valid` is high and `(ir & EXIT_MASK) == EXIT_VAL` (defaults mask 0xFFFF0000, value 0x8FE00000), recording is not frozen and the stack is not empty, the depth falls by one at the next clock edge.
- R3: An instruction that matches either pattern while `ir_valid` is low changes neither the depth nor the stored entries.
- R4: The hardware reset `rst_n` leaves the depth, the peak depth, the error flags and the stored entries unchanged; it clears the freeze bit, the readout cursor and `bus_rdata`.
- R5: A control write (`bus_addr`=1) with bit 0 set empties the stack and zeroes the peak depth and both error flags; in the same cycle it wins over an entry match.
- R6: The peak depth reports the largest depth reached since the last software clear and never falls while entries are popped.
- R7: An entry match while the stack holds DEPTH entries overwrites the top entry with `lnk`, keeps the depth at DEPTH and sets a sticky overflow flag.
- R8: An exit match on an empty stack leaves the depth at 0 and sets a sticky underflow flag.
- R9: Any control write moves the readout cursor to the current top; each data read (`bus_addr`=0) returns the entry under the cursor, zero-extended, and moves the cursor one place toward the bottom; once past the bottom, data reads return 0.
- R10: Bit 1 of a control write sets the freeze bit; while it is set neither entry nor exit matches alter the stack, depth, peak depth or flags.
- R11: A control read returns depth in bits 7:0, peak depth in bits 15:8, overflow in bit 16, underflow in bit 17, freeze in bit 18 and zero elsewhere; every read result appears on `bus_rdata` one clock after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (bus side only) |
| ir | input | 32 | Processor instruction register |
| ir_valid | input | 1 | High for one cycle per newly issued instruction |
| lnk | input | ADDR_W (24) | Processor link register |
| bus_addr | input | 1 | Word select: 0 data, 1 control/status |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |

## Verification
Every result of this block is due exactly one rising edge after its cause: a push, pop, clear or freeze taken at edge N is visible in the status word from edge N on, and a read strobe sampled at edge N puts its word on `bus_rdata` at that same edge. The bench changes inputs on the falling edge and samples one nanosecond after the rising edge that follows, so each check lands in the first cycle the result is due. Effects such as a frozen stack or a reset that must leave the trace intact are checked by reading the status and data words back through the bus after the stimulus.

// File: rtl/ct_pkg.sv
// Package: shared field positions and the status-word packer for the
// call-trace recorder. Assumes depth and peak depth fit in 8 bits.
package ct_pkg;

    localparam int BUS_W       = 32;
    localparam int CNT_FIELD_W = 8;

    // control write bits
    localparam int CTL_CLR_BIT = 0;
    localparam int CTL_FRZ_BIT = 1;

    // status read field positions
    localparam int ST_DEPTH_LSB = 0;
    localparam int ST_PEAK_LSB  = 8;
    localparam int ST_OVF_BIT   = 16;
    localparam int ST_UDF_BIT   = 17;
    localparam int ST_FRZ_BIT   = 18;

    typedef struct packed {
        logic [BUS_W-ST_FRZ_BIT-2:0] pad;
        logic                        frz;
        logic                        udf;
        logic                        ovf;
        logic [CNT_FIELD_W-1:0]      peak;
        logic [CNT_FIELD_W-1:0]      depth;
    } status_t;

    // Build the status word from its parts.
    function automatic logic [BUS_W-1:0] pack_status(
        input logic [CNT_FIELD_W-1:0] depth,
        input logic [CNT_FIELD_W-1:0] peak,
        input logic                   ovf,
        input logic                   udf,
        input logic                   frz
    );
        status_t s;
        s.pad   = '0;
        s.frz   = frz;
        s.udf   = udf;
        s.ovf   = ovf;
        s.peak  = peak;
        s.depth = depth;
        return s;
    endfunction

endpackage

// File: rtl/ct_match.sv
// Module: ct_match
// Compares one instruction word against a value/mask pair. Produces a hit
// only in cycles where the instruction is flagged valid, so a stalled
// instruction held for several cycles is counted once.
module ct_match #(
    parameter int          IR_W = 32,
    parameter logic [31:0] VAL  = 32'h0,
    parameter logic [31:0] MASK = 32'h0
) (
    input  logic [IR_W-1:0] ir,
    input  logic            ir_valid,
    output logic            hit
);

    localparam logic [IR_W-1:0] MASK_W = IR_W'(MASK);
    localparam logic [IR_W-1:0] VAL_W  = IR_W'(VAL) & MASK_W;

    // pattern compare gated by the valid flag
    always_comb begin
        hit = ir_valid && ((ir & MASK_W) == VAL_W);
    end

endmodule

// File: rtl/ct_stack.sv
// Module: ct_stack
// Return-address storage with depth, peak depth and sticky error flags.
// None of this state is touched by the hardware reset: only the clear
// input empties it. Assumes push and pop are already gated by freeze;
// clear beats push, push beats pop.
module ct_stack #(
    parameter int DEPTH  = 32,
    parameter int ADDR_W = 24,
    localparam int PTR_W = $clog2(DEPTH + 1),
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              push,
    input  logic              pop,
    input  logic [ADDR_W-1:0] push_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [ADDR_W-1:0] rd_data,
    output logic [PTR_W-1:0]  depth,
    output logic [PTR_W-1:0]  peak,
    output logic              ovf,
    output logic              udf
);

    localparam logic [PTR_W-1:0] FULL    = PTR_W'(DEPTH);
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(DEPTH - 1);

    logic [ADDR_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  depth_inc;
    logic [PTR_W-1:0]  depth_dec;
    logic              full;
    logic              empty;

    // next-depth helpers
    always_comb begin
        depth_inc = depth + 1'b1;
        depth_dec = depth - 1'b1;
        full      = (depth == FULL);
        empty     = (depth == '0);
    end

    // pointer, peak and flags; deliberately without reset
    always_ff @(posedge clk) begin
        if (clr) begin
            depth <= '0;
            peak  <= '0;
            ovf   <= 1'b0;
            udf   <= 1'b0;
        end else if (push) begin
            if (full) begin
                ovf <= 1'b1;
            end else begin
                depth <= depth_inc;
                if (depth_inc > peak) begin
                    peak <= depth_inc;
                end
            end
        end else if (pop) begin
            if (empty) begin
                udf <= 1'b1;
            end else begin
                depth <= depth_dec;
            end
        end
    end

    // entry storage; full stack overwrites its top slot
    always_ff @(posedge clk) begin
        if (!clr && push) begin
            if (full) begin
                mem[TOP_IDX] <= push_data;
            end else begin
                mem[depth[IDX_W-1:0]] <= push_data;
            end
        end
    end

    // readout port
    always_comb begin
        rd_data = mem[rd_idx];
    end

    // R1
    push_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !clr && !full) |=> (depth == $past(depth) + 1'b1));

    // R2
    pop_shrinks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !clr && !empty) |=> (depth == $past(depth) - 1'b1));

    // R5
    clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (depth == '0 && peak == '0 && !ovf && !udf));

    // R6
    peak_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !$isunknown(depth)) |=> (peak >= depth));

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !clr && full) |=> (ovf && depth == FULL));

    // R8
    underflow_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !clr && empty) |=> (udf && depth == '0));

endmodule

// File: rtl/ct_bus.sv
// Module: ct_bus
// Two-word register interface: control/status word and data word.
// Holds the freeze bit and the readout cursor, both cleared by reset.
// Read data is registered: one clock of latency.
module ct_bus
    import ct_pkg::*;
#(
    parameter int DEPTH  = 32,
    parameter int ADDR_W = 24,
    localparam int PTR_W = $clog2(DEPTH + 1),
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic [PTR_W-1:0]  depth,
    input  logic [PTR_W-1:0]  peak,
    input  logic              ovf,
    input  logic              udf,
    input  logic [ADDR_W-1:0] entry,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              sw_clr,
    output logic              freeze,
    output logic [BUS_W-1:0]  bus_rdata
);

    logic [PTR_W-1:0] cursor;
    logic             ctl_wr;
    logic             data_rd;
    logic [BUS_W-1:0] status_w;
    logic [BUS_W-1:0] entry_w;

    // decode strobes and build read words
    always_comb begin
        ctl_wr   = bus_wr && bus_addr;
        data_rd  = bus_rd && !bus_addr;
        sw_clr   = ctl_wr && bus_wdata[CTL_CLR_BIT];
        rd_idx   = IDX_W'(cursor - 1'b1);
        status_w = pack_status(CNT_FIELD_W'(depth), CNT_FIELD_W'(peak),
                               ovf, udf, freeze);
        entry_w  = (cursor != '0) ? BUS_W'(entry) : '0;
    end

    // freeze bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            freeze <= 1'b0;
        end else if (ctl_wr) begin
            freeze <= bus_wdata[CTL_FRZ_BIT];
        end
    end

    // readout cursor: rewind on control write, step down on data read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cursor <= '0;
        end else if (ctl_wr) begin
            cursor <= sw_clr ? '0 : depth;
        end else if (data_rd && cursor != '0) begin
            cursor <= cursor - 1'b1;
        end
    end

    // registered read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= bus_addr ? status_w : entry_w;
        end
    end

    // R9
    cursor_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !bus_wr && cursor != '0) |=> (cursor == $past(cursor) - 1'b1));

    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd && $past(rst_n)) |=> $stable(bus_rdata));

endmodule

// File: rtl/call_trace_recorder.sv
// Module: call_trace_recorder
// Top level. Watches the instruction and link registers, pushes the link
// value on procedure entry, pops on procedure exit, and exposes the stack
// through two bus words. Assumes ir_valid pulses once per issued
// instruction and DEPTH <= 255.
module call_trace_recorder
    import ct_pkg::*;
#(
    parameter int          DEPTH      = 32,
    parameter int          ADDR_W     = 24,
    parameter logic [31:0] ENTRY_VAL  = 32'hAFE0_0000,
    parameter logic [31:0] ENTRY_MASK = 32'hFFFF_0000,
    parameter logic [31:0] EXIT_VAL   = 32'h8FE0_0000,
    parameter logic [31:0] EXIT_MASK  = 32'hFFFF_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       ir,
    input  logic              ir_valid,
    input  logic [ADDR_W-1:0] lnk,
    input  logic              bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata
);

    localparam int PTR_W = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int N_PAT = 2;

    localparam logic [31:0] PAT_VAL  [N_PAT] = '{ENTRY_VAL,  EXIT_VAL};
    localparam logic [31:0] PAT_MASK [N_PAT] = '{ENTRY_MASK, EXIT_MASK};

    logic [N_PAT-1:0]  hits;
    logic              push;
    logic              pop;
    logic              sw_clr;
    logic              freeze;
    logic [IDX_W-1:0]  rd_idx;
    logic [ADDR_W-1:0] entry;
    logic [PTR_W-1:0]  depth;
    logic [PTR_W-1:0]  peak;
    logic              ovf;
    logic              udf;

    // one matcher per pattern: index 0 entry, index 1 exit
    for (genvar g = 0; g < N_PAT; g++) begin : g_match
        ct_match #(
            .IR_W (32),
            .VAL  (PAT_VAL[g]),
            .MASK (PAT_MASK[g])
        ) u_match (
            .ir       (ir),
            .ir_valid (ir_valid),
            .hit      (hits[g])
        );
    end

    // recording gate
    always_comb begin
        push = hits[0] && !freeze;
        pop  = hits[1] && !freeze;
    end

    ct_stack #(
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W)
    ) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (sw_clr),
        .push      (push),
        .pop       (pop),
        .push_data (lnk),
        .rd_idx    (rd_idx),
        .rd_data   (entry),
        .depth     (depth),
        .peak      (peak),
        .ovf       (ovf),
        .udf       (udf)
    );

    ct_bus #(
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W)
    ) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .depth     (depth),
        .peak      (peak),
        .ovf       (ovf),
        .udf       (udf),
        .entry     (entry),
        .rd_idx    (rd_idx),
        .sw_clr    (sw_clr),
        .freeze    (freeze),
        .bus_rdata (bus_rdata)
    );

    // R10
    freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && !sw_clr) |=> (depth == $past(depth) && ovf == $past(ovf)
                                 && udf == $past(udf)));

    // R3
    invalid_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ir_valid && !sw_clr) |=> (depth == $past(depth)));

endmodule

// File: tb/call_trace_recorder_tb.sv
// Directed bench for call_trace_recorder: one task per scenario.
module call_trace_recorder_tb;

    localparam logic [31:0] ENTRY_IR = 32'hAFE0_0004;
    localparam logic [31:0] EXIT_IR  = 32'h8FE0_0004;
    localparam logic [31:0] OTHER_IR = 32'h4000_0001;
    localparam int          DEPTH    = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ir = '0;
    logic        ir_valid = 1'b0;
    logic [23:0] lnk = '0;
    logic        bus_addr = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int checks = 0;
    int fails  = 0;
    logic [31:0] v;

    always #4 clk = ~clk;

    call_trace_recorder u_dut (
        .clk(clk), .rst_n(rst_n), .ir(ir), .ir_valid(ir_valid), .lnk(lnk),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    function automatic logic [31:0] st(int d, int p, bit o, bit u, bit f);
        return {13'b0, f, u, o, p[7:0], d[7:0]};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one instruction cycle
    task automatic instr(logic [31:0] w, logic [23:0] l, bit valid = 1'b1);
        @(negedge clk);
        ir = w; lnk = l; ir_valid = valid;
        @(posedge clk); #1;
        @(negedge clk);
        ir_valid = 1'b0; ir = OTHER_IR;
    endtask

    task automatic ctl_wr(logic [31:0] d);
        @(negedge clk);
        bus_addr = 1'b1; bus_wr = 1'b1; bus_wdata = d;
        @(posedge clk); #1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(bit a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk); #1;
        d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1;
        check("R4 rdata after reset", bus_rdata, 32'h0);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_basic();
        ctl_wr(32'h1);
        rd(1, v); check("R5 status after clear", v, st(0, 0, 0, 0, 0));
        instr(ENTRY_IR, 24'hA0A0A0);
        rd(1, v); check("R1 depth after one push", v, st(1, 1, 0, 0, 0));
        instr(ENTRY_IR, 24'hB1B1B1);
        instr(ENTRY_IR, 24'hC2C2C2);
        instr(ENTRY_IR, 24'hDDDDDD, 1'b0);
        instr(EXIT_IR, 24'h0, 1'b0);
        rd(1, v); check("R3 invalid cycles ignored", v, st(3, 3, 0, 0, 0));
        instr(OTHER_IR, 24'h123456);
        rd(1, v); check("R11 status fields", v, st(3, 3, 0, 0, 0));
        ctl_wr(32'h0);
        rd(0, v); check("R9 newest first", v, 32'h00C2C2C2);
        rd(0, v); check("R9 second", v, 32'h00B1B1B1);
        rd(0, v); check("R9 third", v, 32'h00A0A0A0);
        rd(0, v); check("R9 past bottom", v, 32'h0);
        instr(EXIT_IR, 24'h0);
        rd(1, v); check("R2 pop and R6 peak kept", v, st(2, 3, 0, 0, 0));
        ctl_wr(32'h0);
        rd(0, v); check("R2 top after pop", v, 32'h00B1B1B1);
    endtask

    task automatic t_freeze_and_reset();
        ctl_wr(32'h2);
        instr(ENTRY_IR, 24'h777777);
        instr(EXIT_IR, 24'h0);
        instr(EXIT_IR, 24'h0);
        instr(EXIT_IR, 24'h0);
        rd(1, v); check("R10 frozen stack unchanged", v, st(2, 3, 0, 0, 1));
        do_reset();
        rd(1, v); check("R4 state kept, freeze cleared", v, st(2, 3, 0, 0, 0));
        rd(0, v); check("R4 cursor cleared by reset", v, 32'h0);
        ctl_wr(32'h0);
        rd(0, v); check("R4 entries kept", v, 32'h00B1B1B1);
    endtask

    task automatic t_overflow();
        ctl_wr(32'h1);
        for (int i = 0; i <= DEPTH; i++) instr(ENTRY_IR, 24'(32'h100 + i));
        rd(1, v); check("R7 overflow status", v, st(DEPTH, DEPTH, 1, 0, 0));
        ctl_wr(32'h0);
        rd(0, v); check("R7 top overwritten", v, 32'h00000120);
        rd(0, v); check("R7 below top intact", v, 32'h0000011E);
    endtask

    task automatic t_underflow();
        ctl_wr(32'h1);
        instr(EXIT_IR, 24'h0);
        rd(1, v); check("R8 underflow status", v, st(0, 0, 0, 1, 0));
        instr(ENTRY_IR, 24'h55AA55);
        rd(1, v); check("R8 flag sticky", v, st(1, 1, 0, 1, 0));
    endtask

    task automatic t_clear_priority();
        ctl_wr(32'h1);
        instr(ENTRY_IR, 24'h010101);
        instr(ENTRY_IR, 24'h020202);
        @(negedge clk);
        ir = ENTRY_IR; lnk = 24'h030303; ir_valid = 1'b1;
        bus_addr = 1'b1; bus_wr = 1'b1; bus_wdata = 32'h1;
        @(posedge clk); #1;
        @(negedge clk);
        ir_valid = 1'b0; bus_wr = 1'b0;
        rd(1, v); check("R5 clear beats push", v, st(0, 0, 0, 0, 0));
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R4 rdata in reset", bus_rdata, 32'h0);
        @(negedge clk); rst_n = 1'b1;
        t_basic();
        t_freeze_and_reset();
        t_overflow();
        t_underflow();
        t_clear_priority();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule